// File: doc/BRIEF.md
# Backplane Vectored Interrupter

This block is the interrupter side of a backplane that carries seven active-low interrupt request lines. Line 1 has the lowest priority and line 7 the highest. A local event pulse is counted as pending, and while anything is pending the block pulls low the request line selected by its configured level. A level of zero switches the block off.

A handler serves the request with an acknowledge read. It drives the acknowledge line low, puts the binary level number on the three low address lines, and lowers data strobes to choose the width of the reply. The block synchronizes the acknowledge, strobe and long-word inputs, then compares the level code with its own level. If they match, it drives its configured status/ID on the enabled byte lanes and asserts the data acknowledge. It removes that acknowledge only after both strobes have risen again. Each completed acknowledge retires one pending event, so the request line stays low while further events are still waiting.

The controller has four states. IDLE waits for a cycle. CHECK compares the level code and the requested width. ACK drives the data and the acknowledge. SKIP waits out a cycle that is meant for another interrupter. The transitions are named start (IDLE to CHECK, acknowledge low with any strobe low), accept (CHECK to ACK), reject (CHECK to SKIP), finish (ACK to IDLE, both strobes high) and drain (SKIP to IDLE, both strobes high).

Top module: `irq_vectorer`

## Requirements
- R1: After reset every request line is high, the data acknowledge is high, no byte lane is enabled and the data output is zero.
- R2: An event pulse with level L in 1..7 sets irq_n_o[L-1] low in the cycle after the pulse, and all other request lines stay high.
- R3: With level 0, event pulses are ignored, no request line goes low, and pending events are discarded.
- R4: A matching acknowledge returns the status/ID with this width encoding: lword_n=0 with ds_n=00 selects 32 bits (lanes 1111, whole value); lword_n=1 with ds_n=00 selects 16 bits (lanes 0011, bits 15:0); lword_n=1 with exactly one ds_n bit low selects 8 bits (lanes 0001, bits 7:0). Data bits outside the enabled lanes read zero, and dtack_n_o goes low.
- R5: An acknowledge whose address code differs from the level, or that arrives when nothing is pending, gets no acknowledge and no driven lanes, and the request state does not change.
- R6: lword_n=0 with only one strobe low is not a legal width. The cycle is ignored as in R5.
- R7: dtack_n_o stays low and the lanes stay driven for as long as any strobe is low. Both are released no later than 3 cycles after both strobes rise.
- R8: A completed matching acknowledge retires one pending event. The request line rises when none remain and stays low otherwise.
- R9: Strobes that go low while the acknowledge line is high start no response.
- R10: The pending count saturates at 2^PEND_W-1, which is 3 by default. After more events than that, exactly 3 acknowledges release the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Local event pulse, one count per high cycle |
| cfg_level_i | input | 3 | Request level 1..7, 0 disables |
| cfg_status_i | input | 32 | Status/ID value returned |
| iack_n_i | input | 1 | Interrupt acknowledge, active low |
| ds_n_i | input | 2 | Data strobes, active low |
| lword_n_i | input | 1 | Long-word flag, active low |
| addr_lo_i | input | 3 | Level code from the handler |
| irq_n_o | output | 7 | Request lines 1..7 at bits 0..6, active low |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| data_o | output | 32 | Status/ID data |
| data_oe_o | output | 4 | Byte lane enables, one bit per byte |

## Verification
Acknowledge inputs pass through two synchronizer flops. The start and accept transitions each add one more edge, so dtack_n_o and the lanes are due on the fourth edge after the strobes fall. The bench samples at the falling clock edge six cycles after it drives them. Release takes two synchronizer edges plus the finish edge, and the bench samples five cycles after it raises the strobes. A request line follows the event pulse after one edge and is checked two cycles later. Expected lanes, data and the pending count come from bench functions and a bench copy of the counting rule, and are compared at those fixed points.

// File: rtl/irq_vectorer_pkg.sv
package irq_vectorer_pkg;
    localparam int LEVELS   = 7;
    localparam int LVL_W    = 3;
    localparam int LANES    = 4;
    localparam int DATA_W   = LANES * 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_ACK   = 2'd2,
        ST_SKIP  = 2'd3
    } vec_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int PEND_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic [PEND_W-1:0] cnt_o,
    output logic              active_o
);
    localparam logic [PEND_W-1:0] CNT_MAX = '1;

    logic [PEND_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else if (dec_i && !inc_i) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o    = cnt_q;
    assign active_o = (cnt_q != '0);

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc_i && !dec_i && !clr_i) |=> (cnt_q == CNT_MAX));

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/irq_lane_sel.sv
module irq_lane_sel
    import irq_vectorer_pkg::*;
(
    input  logic              lword_n_i,
    input  logic [1:0]        ds_n_i,
    input  logic [DATA_W-1:0] status_i,
    output logic              valid_o,
    output logic [LANES-1:0]  lanes_o,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        valid_o = 1'b0;
        lanes_o = '0;
        if (!lword_n_i) begin
            if (ds_n_i == 2'b00) begin
                valid_o = 1'b1;
                lanes_o = 4'b1111;
            end
        end else begin
            unique case (ds_n_i)
                2'b00: begin
                    valid_o = 1'b1;
                    lanes_o = 4'b0011;
                end
                2'b01, 2'b10: begin
                    valid_o = 1'b1;
                    lanes_o = 4'b0001;
                end
                default: begin
                    valid_o = 1'b0;
                    lanes_o = '0;
                end
            endcase
        end
    end

    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign data_o[b*8 +: 8] = lanes_o[b] ? status_i[b*8 +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/irq_vectorer.sv
module irq_vectorer
    import irq_vectorer_pkg::*;
#(
    parameter int PEND_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic [LVL_W-1:0]  cfg_level_i,
    input  logic [DATA_W-1:0] cfg_status_i,
    input  logic              iack_n_i,
    input  logic [1:0]        ds_n_i,
    input  logic              lword_n_i,
    input  logic [LVL_W-1:0]  addr_lo_i,
    output logic [LEVELS-1:0] irq_n_o,
    output logic              dtack_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic [LANES-1:0]  data_oe_o
);
    localparam int SYNC_W = 4;

    vec_state_t state_q, state_d;

    logic [SYNC_W-1:0] sync_raw, sync_q;
    logic              iack_s, lword_s;
    logic [1:0]        ds_s;
    logic              enabled;
    logic              req_active;
    logic [PEND_W-1:0] pend_cnt;
    logic              sel_valid;
    logic [LANES-1:0]  sel_lanes;
    logic [DATA_W-1:0] sel_data;
    logic [LANES-1:0]  lanes_q;
    logic [DATA_W-1:0] data_q;
    logic              cyc_start, strobes_up, code_hit, finish;

    assign sync_raw = {iack_n_i, lword_n_i, ds_n_i};

    irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sync_raw),
        .q_o   (sync_q)
    );

    assign iack_s  = sync_q[3];
    assign lword_s = sync_q[2];
    assign ds_s    = sync_q[1:0];

    assign enabled    = (cfg_level_i != '0);
    assign cyc_start  = !iack_s && (ds_s != 2'b11);
    assign strobes_up = (ds_s == 2'b11);
    assign code_hit   = enabled && req_active && (addr_lo_i == cfg_level_i) && sel_valid;
    assign finish     = (state_q == ST_ACK) && strobes_up;

    irq_pending #(.PEND_W(PEND_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (!enabled),
        .inc_i    (evt_i && enabled),
        .dec_i    (finish),
        .cnt_o    (pend_cnt),
        .active_o (req_active)
    );

    irq_lane_sel u_lanes (
        .lword_n_i (lword_s),
        .ds_n_i    (ds_s),
        .status_i  (cfg_status_i),
        .valid_o   (sel_valid),
        .lanes_o   (sel_lanes),
        .data_o    (sel_data)
    );

    // Next state: start, accept, reject, finish, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cyc_start) state_d = ST_CHECK;
            ST_CHECK: state_d = code_hit ? ST_ACK : ST_SKIP;
            ST_ACK:   if (strobes_up) state_d = ST_IDLE;
            ST_SKIP:  if (strobes_up) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lanes_q <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CHECK && code_hit) begin
                lanes_q <= sel_lanes;
                data_q  <= sel_data;
            end
        end
    end

    // Outputs
    always_comb begin
        dtack_n_o = 1'b1;
        data_oe_o = '0;
        data_o    = '0;
        if (state_q == ST_ACK) begin
            dtack_n_o = 1'b0;
            data_oe_o = lanes_q;
            data_o    = data_q;
        end
    end

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_irq
            assign irq_n_o[l] = !(req_active && (cfg_level_i == LVL_W'(l + 1)));
        end
    endgenerate

    a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n_o));

    a_r5_ack_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n_o) |-> $past(req_active));

    a_r7_hold_while_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n_o && ds_s != 2'b11) |=> !dtack_n_o);

    a_r4_legal_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n_o |-> (data_oe_o == 4'b0001 || data_oe_o == 4'b0011 || data_oe_o == 4'b1111));

    a_r9_no_start_without_iack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && iack_s) |=> (state_q == ST_IDLE));
endmodule

// File: tb/irq_vectorer_tb_top.sv
module irq_vectorer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_i = 1'b0;
    logic [2:0]  cfg_level_i = 3'd0;
    logic [31:0] cfg_status_i = 32'h0;
    logic        iack_n_i = 1'b1;
    logic [1:0]  ds_n_i = 2'b11;
    logic        lword_n_i = 1'b1;
    logic [2:0]  addr_lo_i = 3'd0;
    logic [6:0]  irq_n_o;
    logic        dtack_n_o;
    logic [31:0] data_o;
    logic [3:0]  data_oe_o;

    int checks = 0;
    int failures = 0;
    int pend = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_vectorer dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cfg_level_i(cfg_level_i),
        .cfg_status_i(cfg_status_i), .iack_n_i(iack_n_i), .ds_n_i(ds_n_i),
        .lword_n_i(lword_n_i), .addr_lo_i(addr_lo_i), .irq_n_o(irq_n_o),
        .dtack_n_o(dtack_n_o), .data_o(data_o), .data_oe_o(data_oe_o)
    );

    function automatic logic [3:0] exp_lanes(input logic lw, input logic [1:0] ds);
        if (!lw) return (ds == 2'b00) ? 4'b1111 : 4'b0000;
        if (ds == 2'b00) return 4'b0011;
        if (ds == 2'b01 || ds == 2'b10) return 4'b0001;
        return 4'b0000;
    endfunction

    function automatic logic [31:0] exp_data(input logic [3:0] ln, input logic [31:0] st);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) if (ln[b]) r[b*8 +: 8] = st[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [6:0] exp_irq(input logic [2:0] lvl, input int p);
        logic [6:0] r = 7'h7f;
        if (lvl != 0 && p > 0) r[lvl-1] = 1'b0;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_evt(input int n);
        for (int i = 0; i < n; i++) begin
            evt_i = 1'b1; cyc(1); evt_i = 1'b0;
            if (cfg_level_i != 0 && pend < 3) pend++;
        end
        cyc(2);
        check(irq_n_o == exp_irq(cfg_level_i, pend), "R2 request line", {25'h0, irq_n_o}, {25'h0, exp_irq(cfg_level_i, pend)});
    endtask

    task automatic do_ack(input logic iack, input logic [2:0] code, input logic lw, input logic [1:0] ds);
        logic [3:0] ln;
        bit hit;
        ln  = exp_lanes(lw, ds);
        hit = !iack && (code == cfg_level_i) && (cfg_level_i != 0) && (pend > 0) && (ln != 0);
        if (!hit) ln = 4'b0000;
        addr_lo_i = code; lword_n_i = lw; ds_n_i = ds; iack_n_i = iack;
        cyc(6);
        check(dtack_n_o == !hit, hit ? "R4 dtack" : "R5/R6/R9 no dtack", {31'h0, dtack_n_o}, {31'h0, !hit});
        check(data_oe_o == ln, "R4 lanes", {28'h0, data_oe_o}, {28'h0, ln});
        check(data_o == exp_data(ln, cfg_status_i), "R4 data", data_o, exp_data(ln, cfg_status_i));
        cyc(3);
        check(dtack_n_o == !hit, "R7 held while strobed", {31'h0, dtack_n_o}, {31'h0, !hit});
        ds_n_i = 2'b11; iack_n_i = 1'b1; lword_n_i = 1'b1;
        cyc(5);
        if (hit) pend--;
        check(dtack_n_o == 1'b1 && data_oe_o == 4'b0, "R7 release", {27'h0, dtack_n_o, data_oe_o}, 32'h10);
        check(irq_n_o == exp_irq(cfg_level_i, pend), "R8 request after ack", {25'h0, irq_n_o}, {25'h0, exp_irq(cfg_level_i, pend)});
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1234);
        cyc(3);
        check(irq_n_o == 7'h7f && dtack_n_o && data_oe_o == 0 && data_o == 0, "R1 reset", {25'h0, irq_n_o}, 32'h7f);
        rst_n = 1'b1;
        cyc(2);
        cfg_status_i = 32'hA1B2C3D4;
        // R3 disabled
        cfg_level_i = 3'd0;
        pulse_evt(2);
        check(irq_n_o == 7'h7f, "R3 disabled", {25'h0, irq_n_o}, 32'h7f);
        cfg_level_i = 3'd5;
        cyc(2);
        check(irq_n_o == 7'h7f, "R3 nothing kept", {25'h0, irq_n_o}, 32'h7f);
        // R2, R4 widths
        pulse_evt(3);
        do_ack(1'b0, 3'd5, 1'b0, 2'b00);
        do_ack(1'b0, 3'd5, 1'b1, 2'b00);
        do_ack(1'b0, 3'd5, 1'b1, 2'b10);
        // R5 with nothing pending, then mismatch
        do_ack(1'b0, 3'd5, 1'b1, 2'b00);
        cfg_level_i = 3'd7;
        pulse_evt(1);
        do_ack(1'b0, 3'd6, 1'b1, 2'b00);
        // R6 illegal width, R9 no iack
        do_ack(1'b0, 3'd7, 1'b0, 2'b01);
        do_ack(1'b1, 3'd7, 1'b1, 2'b00);
        do_ack(1'b0, 3'd7, 1'b1, 2'b01);
        // R10 saturation
        cfg_level_i = 3'd1;
        pulse_evt(5);
        for (int k = 0; k < 3; k++) do_ack(1'b0, 3'd1, 1'b1, 2'b00);
        check(irq_n_o == 7'h7f, "R10 released after three", {25'h0, irq_n_o}, 32'h7f);
        // R3 clear of pending
        pulse_evt(2);
        cfg_level_i = 3'd0;
        cyc(2);
        pend = 0;
        cfg_level_i = 3'd3;
        cyc(2);
        check(irq_n_o == 7'h7f, "R3 pending discarded", {25'h0, irq_n_o}, 32'h7f);
        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [2:0] lvl;
            logic [2:0] code;
            lvl = 3'($urandom_range(1, 7));
            cfg_level_i = lvl;
            cfg_status_i = $urandom;
            cyc(1);
            pulse_evt($urandom_range(0, 3));
            code = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : lvl;
            do_ack(($urandom_range(0, 7) == 0), code, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule